// File: doc/BRIEF.md
# Per-Lane Packet Dword FIFO

This block buffers packet data that arrives already realigned on a wide bus. It splits the bus into `LANES = DATA_W/32` independent 32-bit queues. Each queue entry holds one dword and a last-of-payload flag. Lane 0 also holds a packet-first flag. The producer offers one beat at a time. The beat carries a per-lane mask, and only the masked lanes take an entry. On the consumer side every lane has its own valid/ready pair, so any subset of lanes can be drained in a given cycle.

Storage is sized in whole maximum-size packets. The per-lane depth is the packet count times the maximum payload in dwords, divided by the lane count and rounded up to a power of two. An optional one-entry register stage sits at each lane output and adds one entry of capacity.

Back-pressure works as follows:
- Write side: a beat transfers on a rising clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low the producer must hold the beat.
- Read side: lane i transfers when `rd_valid[i]` and `rd_ready[i]` are both high. While ready is low, the lane's valid and data stay steady.
- Combinational path: `wr_ready` depends on `rd_ready` in the same cycle.

Top module: `lane_dword_fifo`

## Requirements
- R1: Each lane pops only on its own `rd_valid[i] && rd_ready[i]`. While that lane's valid is high and its ready is low, its valid, data and last flag stay stable.
- R2: On a write transfer, lane i takes an entry only if `wr_lane_mask[i]` is 1. Unmasked lanes are unchanged.
- R3: Each lane delivers its entries in write order. Lane i's dword is taken from `wr_data[32*i+31:32*i]` and returned on `rd_data` at the same bit position, together with its `wr_last[i]` flag.
- R4: The first flag written with a lane 0 entry is returned on `rd_first` while that entry is at the lane 0 output. `rd_first` is 0 whenever `rd_valid[0]` is 0.
- R5: `wr_ready` is 1 exactly when every lane either has a free entry or is popping in the same cycle.
- R6: Each lane holds exactly `DEPTH + OUT_REG` entries, where `DEPTH` is the power of two at or above `PKTS*MAX_BYTES/4/LANES` (minimum 2).
- R7: With `OUT_REG=1`, an entry written at clock edge k into an empty lane raises that lane's valid after edge k+1, and not before.
- R8: Reset is synchronous and active high. After it, every lane is empty, all `rd_valid` bits are 0, `rd_first` is 0 and `wr_ready` is 1.
- R9: A beat presented while `wr_valid` is 0, or while `wr_ready` is 0, pushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Producer beat valid |
| wr_ready | output | 1 | All lanes can accept |
| wr_data | input | DATA_W | Beat data, lane i in bits 32*i+31:32*i |
| wr_lane_mask | input | LANES | Lanes that take an entry |
| wr_last | input | LANES | Per-lane last-of-payload flags |
| wr_first | input | 1 | Packet-first flag for lane 0 |
| rd_ready | input | LANES | Per-lane consumer ready |
| rd_valid | output | LANES | Per-lane entry available |
| rd_data | output | DATA_W | Per-lane output dwords |
| rd_last | output | LANES | Per-lane last flags |
| rd_first | output | 1 | Packet-first flag at lane 0 |

## Verification
The bench sweeps every write mask against every read mask on a two-lane configuration and compares each popped entry with per-lane reference queues. This catches lanes swapped in the data bus and unmasked lanes that still push, both of which appear as reordered or extra entries. It fills every lane to capacity and then checks that `wr_ready` falls at exactly `DEPTH+1` entries and rises again when all lanes pop in the same cycle; a design that ignores the same-cycle pop stalls there, and one that overflows returns corrupted order. It also measures the two-edge read latency and confirms that held-off beats and reset leave the lanes empty.

// File: rtl/lfifo_pkg.sv
package lfifo_pkg;
  localparam int unsigned DWORD_W = 32;

  // smallest power of two >= v, floored at 2
  function automatic int unsigned pow2_at_least(int unsigned v);
    int unsigned r;
    r = 2;
    for (int k = 0; k < 31; k++) begin
      if (r < v) r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int unsigned EW    = 33,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [EW-1:0] din,
  input  logic          pop,
  output logic [EW-1:0] dout,
  output logic          nonempty,
  output logic          full,
  output logic [CW-1:0] fill
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout     = mem[rp];
  assign nonempty = (cnt != '0);
  assign full     = (cnt == CW'(DEPTH));
  assign fill     = cnt;
endmodule

// File: rtl/lane_stage.sv
module lane_stage #(
  parameter int unsigned EW  = 33,
  parameter bit          REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [EW-1:0] in_data,
  output logic          in_pop,
  output logic          out_valid,
  output logic [EW-1:0] out_data,
  input  logic          out_ready
);
  if (REG) begin : g_reg
    logic          v;
    logic [EW-1:0] d;
    logic          load;
    assign load   = in_valid && (!v || out_ready);
    assign in_pop = load;
    always_ff @(posedge clk) begin
      if (rst) begin
        v <= 1'b0;
      end else if (load) begin
        v <= 1'b1;
      end else if (out_ready) begin
        v <= 1'b0;
      end
    end
    always_ff @(posedge clk) begin
      if (load) d <= in_data;
    end
    assign out_valid = v;
    assign out_data  = d;
  end else begin : g_thru
    assign in_pop    = in_valid && out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/lane_dword_fifo.sv
module lane_dword_fifo
  import lfifo_pkg::*;
#(
  parameter int unsigned DATA_W    = 128,
  parameter int unsigned PKTS      = 10,
  parameter int unsigned MAX_BYTES = 256,
  parameter bit          OUT_REG   = 1'b1,
  localparam int unsigned LANES    = DATA_W / DWORD_W,
  localparam int unsigned DEPTH    = pow2_at_least((PKTS * MAX_BYTES / 4 + LANES - 1) / LANES),
  localparam int unsigned CW       = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_lane_mask,
  input  logic [LANES-1:0]  wr_last,
  input  logic              wr_first,
  input  logic [LANES-1:0]  rd_ready,
  output logic [LANES-1:0]  rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [LANES-1:0]  rd_last,
  output logic              rd_first
);
  logic [LANES-1:0]          room;
  logic [LANES-1:0][CW-1:0]  lane_fill;
  logic                      beat_go;

  assign beat_go  = wr_valid && wr_ready;
  assign wr_ready = &room;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int unsigned EW = DWORD_W + 1 + ((i == 0) ? 1 : 0);
    logic [EW-1:0] push_entry, fifo_out, stage_out;
    logic          f_nonempty, f_full, f_pop, push;

    assign push = beat_go && wr_lane_mask[i];

    if (i == 0) begin : g_head
      assign push_entry = {wr_first, wr_last[i], wr_data[i*DWORD_W +: DWORD_W]};
      assign rd_first   = stage_out[DWORD_W+1] && rd_valid[i];
    end else begin : g_body
      assign push_entry = {wr_last[i], wr_data[i*DWORD_W +: DWORD_W]};
    end

    lane_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .push     (push),
      .din      (push_entry),
      .pop      (f_pop),
      .dout     (fifo_out),
      .nonempty (f_nonempty),
      .full     (f_full),
      .fill     (lane_fill[i])
    );

    lane_stage #(.EW(EW), .REG(OUT_REG)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (f_nonempty),
      .in_data   (fifo_out),
      .in_pop    (f_pop),
      .out_valid (rd_valid[i]),
      .out_data  (stage_out),
      .out_ready (rd_ready[i])
    );

    assign room[i] = !f_full || f_pop;
    assign rd_data[i*DWORD_W +: DWORD_W] = stage_out[DWORD_W-1:0];
    assign rd_last[i] = stage_out[DWORD_W];
  end
endmodule

// File: rtl/lane_dword_fifo_chk.sv
module lane_dword_fifo_chk #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned LANES  = 4,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned CW     = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic [LANES-1:0]         rd_valid,
  input logic [LANES-1:0]         rd_ready,
  input logic [DATA_W-1:0]        rd_data,
  input logic [LANES-1:0]         rd_last,
  input logic                     rd_first,
  input logic                     wr_ready,
  input logic [LANES-1:0][CW-1:0] lane_fill
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R8: the cycle after reset, no lane offers data and the write side is open
  always_ff @(posedge clk) begin
    if (rst_seen && !rst) begin
      p_reset_empty_r8: assert (rd_valid == '0 && wr_ready)
        else $error("lanes not empty after reset");
    end
  end

  p_first_gated_r4: assert property (@(posedge clk) disable iff (rst)
    rd_first |-> rd_valid[0]);

  for (genvar i = 0; i < LANES; i++) begin : g_l
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
      rd_valid[i] && !rd_ready[i] |=> rd_valid[i] && $stable(rd_data[i*32 +: 32]) && $stable(rd_last[i]));
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
      lane_fill[i] <= CW'(DEPTH));
  end
endmodule

bind lane_dword_fifo lane_dword_fifo_chk #(
  .DATA_W(DATA_W), .LANES(LANES), .DEPTH(DEPTH), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .rd_last(rd_last), .rd_first(rd_first),
  .wr_ready(wr_ready), .lane_fill(lane_fill)
);

// File: tb/lane_dword_fifo_tb.sv
module lane_dword_fifo_tb;
  localparam int CLK_P = 10;
  localparam int DW    = 64;
  localparam int L     = 2;
  localparam int CAP   = 4 + 1;   // DEPTH 4 (1*32/4/2) plus output register

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_valid;
  logic          wr_ready;
  logic [DW-1:0] wr_data;
  logic [L-1:0]  wr_lane_mask, wr_last, rd_ready, rd_valid, rd_last;
  logic          wr_first, rd_first;
  logic [DW-1:0] rd_data;

  int nchk = 0, nbad = 0, tick = 0;
  logic [33:0] mq [L][$];
  logic [L-1:0] s_valid;
  logic s_wr_ready;

  always #(CLK_P/2) clk = ~clk;

  lane_dword_fifo #(.DATA_W(DW), .PKTS(1), .MAX_BYTES(32), .OUT_REG(1'b1)) u_dut (
    .clk, .rst, .wr_valid, .wr_ready, .wr_data, .wr_lane_mask, .wr_last, .wr_first,
    .rd_ready, .rd_valid, .rd_data, .rd_last, .rd_first
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle: drive, sample, check against the reference queues, update them
  task automatic step(input bit wv, input logic [L-1:0] m, input logic [L-1:0] lst,
                      input bit fst, input logic [DW-1:0] d, input logic [L-1:0] rr);
    bit exp_rdy;
    @(negedge clk);
    wr_valid = wv; wr_lane_mask = m; wr_last = lst; wr_first = fst; wr_data = d; rd_ready = rr;
    #1;
    s_valid = rd_valid; s_wr_ready = wr_ready;
    exp_rdy = 1'b1;
    for (int i = 0; i < L; i++)
      if (mq[i].size() >= CAP && !(rd_valid[i] && rr[i])) exp_rdy = 1'b0;
    chk(wr_ready == exp_rdy, "R5 wr_ready", wr_ready, exp_rdy);
    if (!rd_valid[0]) chk(rd_first == 1'b0, "R4 first gated", rd_first, 0);
    for (int i = 0; i < L; i++) begin
      if (rd_valid[i]) begin
        chk(mq[i].size() > 0, "R2 valid without write", 1, 0);
        if (rr[i] && mq[i].size() > 0) begin
          logic [33:0] e;
          e = mq[i].pop_front();
          chk(rd_data[i*32 +: 32] == e[31:0], "R3 data", rd_data[i*32 +: 32], e[31:0]);
          chk(rd_last[i] == e[32], "R3 last", rd_last[i], e[32]);
          if (i == 0) chk(rd_first == e[33], "R4 first", rd_first, e[33]);
        end
      end
    end
    if (wv && wr_ready)
      for (int i = 0; i < L; i++)
        if (m[i]) mq[i].push_back({(i == 0) ? fst : 1'b0, lst[i], d[i*32 +: 32]});
    tick++;
  endtask

  task automatic settle_check(input string req);
    step(0, '0, '0, 0, '0, '0);
    step(0, '0, '0, 0, '0, '0);
    for (int i = 0; i < L; i++)
      chk(s_valid[i] == (mq[i].size() > 0), req, s_valid[i], mq[i].size() > 0);
  endtask

  task automatic drain();
    for (int k = 0; k < 3 * CAP; k++) step(0, '0, '0, 0, '0, '1);
    for (int i = 0; i < L; i++) chk(mq[i].size() == 0 && !s_valid[i], "R3 drained", mq[i].size(), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_valid = 0; wr_lane_mask = '0; wr_last = '0; wr_first = 0; wr_data = '0; rd_ready = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(rd_valid == '0, "R8 valid after reset", rd_valid, 0);
    chk(wr_ready == 1'b1, "R8 ready after reset", wr_ready, 1);
    chk(rd_first == 1'b0, "R8 first after reset", rd_first, 0);

    // R7 latency: write at edge k, valid only after edge k+1
    step(1, 2'b01, 2'b01, 1, 64'h0000_0000_cafe_0001, '0);
    chk(s_valid[0] == 0, "R7 before write", s_valid[0], 0);
    step(0, '0, '0, 0, '0, '0);
    chk(s_valid[0] == 0, "R7 one edge after", s_valid[0], 0);
    step(0, '0, '0, 0, '0, '0);
    chk(s_valid[0] == 1, "R7 two edges after", s_valid[0], 1);
    drain();

    // R9: held-off beats push nothing
    for (int k = 0; k < 4; k++) step(0, '1, '1, 1, 64'h1234 + k, '0);
    settle_check("R9 wr_valid low ignored");

    // R6 fill to capacity, then R9 blocked beats
    for (int k = 0; k < CAP + 4; k++) step(1, '1, 2'(k), k[0], {32'(k + 100), 32'(k + 200)}, '0);
    for (int i = 0; i < L; i++) chk(mq[i].size() == CAP, "R6 capacity", mq[i].size(), CAP);
    chk(s_wr_ready == 0, "R6 full ready low", s_wr_ready, 0);
    // R5: full lanes all popping admit a beat in the same cycle
    step(1, '1, '0, 0, {32'h77, 32'h66}, '1);
    chk(s_wr_ready == 1, "R5 push on full with pop", s_wr_ready, 1);
    drain();

    // R1/R2/R3 sweep: every write mask against every read mask
    for (int wm = 0; wm < (1 << L); wm++)
      for (int rm = 0; rm < (1 << L); rm++)
        for (int rep = 0; rep < 6; rep++) begin
          step(1, L'(wm), L'(rep + rm), rep[1], {32'(tick * 3 + 1), 32'(tick * 5 + 2)}, L'(rm));
        end
    settle_check("R2 masked pushes only");
    drain();

    // R8 mid-run reset empties lanes
    for (int k = 0; k < 3; k++) step(1, '1, '0, 0, 64'(k), '0);
    @(negedge clk); rst = 1'b1; wr_valid = 0;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < L; i++) mq[i].delete();
    #1;
    chk(rd_valid == '0, "R8 reset empties", rd_valid, 0);
    settle_check("R8 stays empty");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule